// File: doc/BRIEF.md
# Paged Bank Address Translator

This block maps a 16-bit word virtual address onto a physical bank and an in-bank offset. The virtual space is cut into sixteen banks of 4 KiW each. The top four address bits pick a bank, and the low twelve bits pass through unchanged as the offset. Each bank has a pair of descriptor words in an internal table. The even word holds the physical bank number. The odd word holds the ROM/RAM select and three protection attributes. Every lookup checks the access type (read, write or instruction fetch) and the current privilege level against those attributes, and raises a combinational fault flag when an access breaks them.

Software in supervisor mode reads and writes the table through a word-indexed port. A write attempted from user mode is dropped, and the block reports it on a one-cycle privilege strobe. During interrupt entry, the interrupt logic can force bank 0 onto the internal processor bank 0, in ROM or RAM as a status bit chooses. When paging is switched off, every bank maps straight onto the RAM bank of the same number, with no checks.

Top module: `mmu_bank_xlate`

## Requirements
- R1: `offset` always equals `va[11:0]`.
- R2: With paging on and no force, `pbank` equals the low 8 bits of descriptor word 2n, where n = `va[15:12]`. `rom_sel` equals bit 15 of word 2n+1 (1 = ROM).
- R3: After reset, bank 0 has word 0 = $0000 and word 1 = $8000 (ROM bank 0). Every bank n ≥ 1 has word 2n = n and word 2n+1 = $0000.
- R4: Bit 14 of word 2n+1 makes bank n supervisor-only. Any access to that bank with `sup_mode`=0 raises `fault`.
- R5: Bit 13 of word 2n+1 prohibits writes. An access with `acc`=2'b01 (write) to that bank raises `fault`.
- R6: Bit 12 of word 2n+1 prohibits execution. An access with `acc`=2'b10 (fetch) raises `fault`. A read (`acc`=2'b00) is not affected by bits 13 or 12.
- R7: With `paging_on`=0, `pbank` = `va[15:12]`, `rom_sel`=0 and `fault`=0.
- R8: With `force_b0`=1 and `va[15:12]`=0, the result is `pbank`=0, `rom_sel` = NOT `irq_ram`, and `fault`=0. Other banks are unaffected.
- R9: A write with `dsc_we`=1 and `sup_mode`=1 stores `dsc_wdata` at `dsc_idx`. The new value is seen by translation and by `dsc_rdata` from the next cycle on.
- R10: A write with `sup_mode`=0 leaves the table unchanged. `priv_fault` is 1 in exactly the cycle that follows it.
- R11: `dsc_rdata` shows the word at `dsc_idx` when `sup_mode`=1, and reads as $0000 otherwise.
- R12: A translation in the same cycle as a write to its own descriptor uses the old descriptor contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va | input | 16 | Virtual word address |
| acc | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| sup_mode | input | 1 | Supervisor mode |
| paging_on | input | 1 | Paging enable |
| force_b0 | input | 1 | Interrupt logic forces bank 0 to internal bank |
| irq_ram | input | 1 | Forced bank 0 selects RAM (1) or ROM (0) |
| dsc_idx | input | 5 | Descriptor word index |
| dsc_we | input | 1 | Descriptor write request |
| dsc_wdata | input | 16 | Descriptor write data |
| dsc_rdata | output | 16 | Descriptor read data |
| pbank | output | 8 | Physical bank number |
| rom_sel | output | 1 | 1 selects ROM, 0 RAM |
| offset | output | 12 | In-bank word offset |
| fault | output | 1 | Protection fault for the current access |
| priv_fault | output | 1 | One-cycle strobe for a rejected user-mode write |

## Verification
Two functions can land in the same cycle: a supervisor rewrite of a bank's descriptor, and a translation through that same bank. The bench drives both together. It samples `pbank` before the clock edge, where it must still show the old physical bank. It samples again after the edge, where the new one must appear. A second collision is checked the same way: a forced bank-0 remap meets a user-mode access to a protected bank, and only bank 0 may change its mapping.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int VA_W    = 16;
    localparam int OFS_W   = 12;
    localparam int BSEL_W  = VA_W - OFS_W;
    localparam int NBANK   = 1 << BSEL_W;
    localparam int DW      = 16;
    localparam int PB_W    = 8;
    localparam int IDX_W   = $clog2(2 * NBANK);

    localparam int ROM_BIT = 15;
    localparam int SUP_BIT = 14;
    localparam int NWR_BIT = 13;
    localparam int NEX_BIT = 12;

    typedef enum logic [1:0] {
        ACC_RD = 2'b00,
        ACC_WR = 2'b01,
        ACC_FX = 2'b10
    } acc_e;

    typedef struct packed {
        logic rom;
        logic sup_only;
        logic no_wr;
        logic no_ex;
    } attr_t;

    typedef struct packed {
        logic [PB_W-1:0] pbank;
        logic            rom;
        logic            fault;
    } xlate_t;

    function automatic attr_t unpack_attr(input logic [DW-1:0] w);
        attr_t a;
        a.rom      = w[ROM_BIT];
        a.sup_only = w[SUP_BIT];
        a.no_wr    = w[NWR_BIT];
        a.no_ex    = w[NEX_BIT];
        return a;
    endfunction

    function automatic logic attr_violation(input attr_t a, input acc_e k, input logic sup);
        logic v;
        v = 1'b0;
        if (a.sup_only && !sup) v = 1'b1;
        if (a.no_wr && k == ACC_WR) v = 1'b1;
        if (a.no_ex && k == ACC_FX) v = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/mmu_desc_table.sv
module mmu_desc_table
    import mmu_pkg::*;
#(
    parameter int NB  = NBANK,
    parameter int W   = DW,
    parameter int IW  = IDX_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          sup,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          priv_strobe,
    output logic [W-1:0]  map_word [NB],
    output logic [W-1:0]  attr_word [NB]
);
    localparam logic [W-1:0] BOOT_ATTR0 = W'(1) << ROM_BIT;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [IW-1:0] IDX_MAP  = IW'(2 * b);
        localparam logic [IW-1:0] IDX_ATTR = IW'(2 * b + 1);
        localparam logic [W-1:0]  RST_MAP  = W'(b);
        localparam logic [W-1:0]  RST_ATTR = (b == 0) ? BOOT_ATTR0 : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                map_word[b]  <= RST_MAP;
                attr_word[b] <= RST_ATTR;
            end else if (we && sup) begin
                if (idx == IDX_MAP)  map_word[b]  <= wdata;
                if (idx == IDX_ATTR) attr_word[b] <= wdata;
            end
        end
    end

    logic [W-1:0] sel_word;
    always_comb begin
        if (idx[0]) sel_word = attr_word[idx[IW-1:1]];
        else        sel_word = map_word[idx[IW-1:1]];
        rdata = sup ? sel_word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) priv_strobe <= 1'b0;
        else     priv_strobe <= we && !sup;
    end
endmodule

// File: rtl/mmu_xlate_path.sv
module mmu_xlate_path
    import mmu_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int W  = DW
)(
    input  logic [VA_W-1:0] va,
    input  acc_e            kind,
    input  logic            sup,
    input  logic            paging_on,
    input  logic            force_b0,
    input  logic            irq_ram,
    input  logic [W-1:0]    map_word [NB],
    input  logic [W-1:0]    attr_word [NB],
    output xlate_t          res
);
    logic [BSEL_W-1:0] vbank;
    attr_t             attr;
    logic              forced;

    always_comb begin
        vbank  = va[VA_W-1:OFS_W];
        attr   = unpack_attr(attr_word[vbank]);
        forced = force_b0 && (vbank == '0);

        if (!paging_on) begin
            res.pbank = PB_W'(vbank);
            res.rom   = 1'b0;
            res.fault = 1'b0;
        end else if (forced) begin
            res.pbank = '0;
            res.rom   = !irq_ram;
            res.fault = 1'b0;
        end else begin
            res.pbank = map_word[vbank][PB_W-1:0];
            res.rom   = attr.rom;
            res.fault = attr_violation(attr, kind, sup);
        end
    end
endmodule

// File: rtl/mmu_bank_xlate.sv
module mmu_bank_xlate
    import mmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   va,
    input  logic [1:0]        acc,
    input  logic              sup_mode,
    input  logic              paging_on,
    input  logic              force_b0,
    input  logic              irq_ram,
    input  logic [IDX_W-1:0]  dsc_idx,
    input  logic              dsc_we,
    input  logic [DW-1:0]     dsc_wdata,
    output logic [DW-1:0]     dsc_rdata,
    output logic [PB_W-1:0]   pbank,
    output logic              rom_sel,
    output logic [OFS_W-1:0]  offset,
    output logic              fault,
    output logic              priv_fault
);
    logic [DW-1:0] map_word  [NBANK];
    logic [DW-1:0] attr_word [NBANK];
    xlate_t        res;
    acc_e          kind;

    assign kind = acc_e'(acc);

    mmu_desc_table #(.NB(NBANK), .W(DW), .IW(IDX_W)) u_tbl (
        .clk         (clk),
        .rst         (rst),
        .sup         (sup_mode),
        .we          (dsc_we),
        .idx         (dsc_idx),
        .wdata       (dsc_wdata),
        .rdata       (dsc_rdata),
        .priv_strobe (priv_fault),
        .map_word    (map_word),
        .attr_word   (attr_word)
    );

    mmu_xlate_path #(.NB(NBANK), .W(DW)) u_path (
        .va        (va),
        .kind      (kind),
        .sup       (sup_mode),
        .paging_on (paging_on),
        .force_b0  (force_b0),
        .irq_ram   (irq_ram),
        .map_word  (map_word),
        .attr_word (attr_word),
        .res       (res)
    );

    assign pbank   = res.pbank;
    assign rom_sel = res.rom;
    assign fault   = res.fault;
    assign offset  = va[OFS_W-1:0];
endmodule

// File: rtl/mmu_bank_xlate_chk.sv
module mmu_bank_xlate_chk
    import mmu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [VA_W-1:0]   va,
    input logic              sup_mode,
    input logic              paging_on,
    input logic              force_b0,
    input logic              irq_ram,
    input logic [IDX_W-1:0]  dsc_idx,
    input logic              dsc_we,
    input logic [DW-1:0]     dsc_wdata,
    input logic [DW-1:0]     dsc_rdata,
    input logic [PB_W-1:0]   pbank,
    input logic              rom_sel,
    input logic              fault,
    input logic              priv_fault
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R10
    user_write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (dsc_we && !sup_mode) |=> priv_fault);

    // R10
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        priv_fault |-> $past(dsc_we && !sup_mode));

    // R7
    paging_off_clean_chk: assert property (@(posedge clk) disable iff (rst)
        !paging_on |-> (!fault && !rom_sel && pbank == PB_W'(va[VA_W-1:OFS_W])));

    // R8
    forced_bank0_chk: assert property (@(posedge clk) disable iff (rst)
        (paging_on && force_b0 && va[VA_W-1:OFS_W] == '0) |->
            (pbank == '0 && rom_sel == !irq_ram && !fault));

    // R11
    user_read_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !sup_mode |-> dsc_rdata == '0);

    // R9
    write_readback_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (sup_mode && $past(dsc_we && sup_mode) && dsc_idx == $past(dsc_idx)) |->
            dsc_rdata == $past(dsc_wdata));
endmodule

bind mmu_bank_xlate mmu_bank_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .va         (va),
    .sup_mode   (sup_mode),
    .paging_on  (paging_on),
    .force_b0   (force_b0),
    .irq_ram    (irq_ram),
    .dsc_idx    (dsc_idx),
    .dsc_we     (dsc_we),
    .dsc_wdata  (dsc_wdata),
    .dsc_rdata  (dsc_rdata),
    .pbank      (pbank),
    .rom_sel    (rom_sel),
    .fault      (fault),
    .priv_fault (priv_fault)
);

// File: tb/sim_mmu_bank_xlate.sv
module sim_mmu_bank_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] va = '0;
    logic [1:0]  acc = '0;
    logic        sup_mode = 1'b1;
    logic        paging_on = 1'b1;
    logic        force_b0 = 1'b0;
    logic        irq_ram = 1'b0;
    logic [4:0]  dsc_idx = '0;
    logic        dsc_we = 1'b0;
    logic [15:0] dsc_wdata = '0;
    logic [15:0] dsc_rdata;
    logic [7:0]  pbank;
    logic        rom_sel;
    logic [11:0] offset;
    logic        fault;
    logic        priv_fault;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mmu_bank_xlate u0 (
        .clk(clk), .rst(rst), .va(va), .acc(acc), .sup_mode(sup_mode),
        .paging_on(paging_on), .force_b0(force_b0), .irq_ram(irq_ram),
        .dsc_idx(dsc_idx), .dsc_we(dsc_we), .dsc_wdata(dsc_wdata),
        .dsc_rdata(dsc_rdata), .pbank(pbank), .rom_sel(rom_sel),
        .offset(offset), .fault(fault), .priv_fault(priv_fault)
    );

    // fields: va[31:16] acc[15:14] sup[13] pg[12] frc[11] iram[10] pbank[9:2] rom[1] flt[0]
    localparam logic [31:0] VEC [14] = '{
        {16'h0123, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R2
        {16'h3ABC, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h45, 1'b0, 1'b1}, // R5
        {16'h3ABC, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h45, 1'b0, 1'b0}, // R6 read
        {16'h3ABC, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h45, 1'b0, 1'b0}, // R5
        {16'h4001, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b1}, // R4
        {16'h4001, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0}, // R4
        {16'h4001, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b1}, // R6
        {16'h5FFF, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h12, 1'b0, 1'b1}, // R6
        {16'h5FFF, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0}, // R6
        {16'h4001, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0, 1'b0}, // R7
        {16'h0123, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}, // R8
        {16'h0123, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0}, // R8
        {16'h4001, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA1, 1'b1, 1'b1}, // R8
        {16'h7222, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] i, input logic [15:0] d);
        @(negedge clk);
        sup_mode = 1'b1; dsc_idx = i; dsc_wdata = d; dsc_we = 1'b1;
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] i, input logic [15:0] exp, input string req);
        @(negedge clk);
        sup_mode = 1'b1; dsc_idx = i;
        #2;
        check(req, 32'(dsc_rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 reset contents
        rd(5'd0, 16'h0000, "R3");
        rd(5'd1, 16'h8000, "R3");
        rd(5'd30, 16'h000F, "R3");
        rd(5'd31, 16'h0000, "R3");

        // R11 user-mode read blanked
        @(negedge clk);
        sup_mode = 1'b0; dsc_idx = 5'd1;
        #2;
        check("R11", 32'(dsc_rdata), 32'h0);

        // R10 user-mode write dropped, one-cycle strobe
        @(negedge clk);
        sup_mode = 1'b0; dsc_idx = 5'd1; dsc_wdata = 16'h0000; dsc_we = 1'b1;
        #2;
        check("R10", 32'(priv_fault), 32'h0);
        @(negedge clk);
        dsc_we = 1'b0;
        #2;
        check("R10", 32'(priv_fault), 32'h1);
        @(negedge clk);
        #2;
        check("R10", 32'(priv_fault), 32'h0);
        rd(5'd1, 16'h8000, "R10");

        // R9 configure banks 3, 4, 5
        wr(5'd6,  16'h0045); wr(5'd7,  16'h2000);
        wr(5'd8,  16'h00A1); wr(5'd9,  16'hD000);
        wr(5'd10, 16'h0012); wr(5'd11, 16'h1000);
        rd(5'd9, 16'hD000, "R9");

        // table walk
        for (int n = 0; n < 14; n++) begin
            logic [31:0] v;
            v = VEC[n];
            @(negedge clk);
            va = v[31:16]; acc = v[15:14]; sup_mode = v[13];
            paging_on = v[12]; force_b0 = v[11]; irq_ram = v[10];
            #2;
            check($sformatf("R2/R4-R8 vec%0d pbank", n), 32'(pbank), 32'(v[9:2]));
            check($sformatf("R2/R8 vec%0d rom_sel", n), 32'(rom_sel), 32'(v[1]));
            check($sformatf("R4/R5/R6 vec%0d fault", n), 32'(fault), 32'(v[0]));
            check($sformatf("R1 vec%0d offset", n), 32'(offset), 32'(v[27:16]));
        end

        // R12 write and translate the same bank in one cycle
        @(negedge clk);
        force_b0 = 1'b0; paging_on = 1'b1; acc = 2'b00;
        sup_mode = 1'b1; va = 16'h3000;
        dsc_idx = 5'd6; dsc_wdata = 16'h0077; dsc_we = 1'b1;
        #2;
        check("R12 old mapping", 32'(pbank), 32'h45);
        @(negedge clk);
        dsc_we = 1'b0;
        #2;
        check("R12 new mapping", 32'(pbank), 32'h77);
        check("R9 readback", 32'(dsc_rdata), 32'h0077);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule